// File: doc/BRIEF.md
# Sample-Rate Clock Divider with External Phase Alignment

This block divides a fast input clock into a sample-rate clock enable. It counts input clock cycles and raises a one-cycle enable once every N cycles, where N is programmable from 1 to 8. Several of these dividers can run from the same input clock. When they also share one SYNC line, a rising edge on that line resets each divider's counter, so every divider then raises its enable on the same input clock edge.

The SYNC line arrives as a single-ended level. Inside the block it passes through a two-stage resampler clocked by the input clock. After that an edge detector turns each rising edge into a single event, however long SYNC stays high. A mode input picks between two behaviours. In continuous mode every SYNC edge realigns the divider. In one-shot mode only the first edge after arming realigns it, and a sticky flag then records that the alignment took place. A change of the divide ratio waits until the current output period has finished, so no short period is ever produced.

Top module: `sclk_div_align`

## Requirements
- R1: `sync_in` is resampled through two flops and then edge-detected. If `sync_in` is first seen high at input clock edge k, the realignment takes effect at edge k+2. A SYNC level held high for many cycles causes exactly one realignment.
- R2: When a realignment takes effect at edge k+2, `div_en` and `realign` are both high in the cycle after that edge. `realign` lasts one cycle. `div_en` then repeats every N cycles, counted from that cycle.
- R3: `div_code` holds the divide ratio minus one, so the value v gives a period of v+1 input cycles (`div_code`=7 gives one `div_en` cycle in every 8).
- R4: With `div_code`=0 the ratio is one and `div_en` is high in every cycle.
- R5: A new `div_code` value is picked up only when the counter wraps at the end of the current period, or when a realignment takes place. The period in progress always completes at the old length.
- R6: With `one_shot`=0, every rising edge of SYNC realigns the divider and pulses `realign`, whatever the phase of the divider at that moment.
- R7: With `one_shot`=1, the first SYNC edge after arming realigns the divider and sets `synced`. While `synced` is set, later SYNC edges cause no `realign` pulse and leave the `div_en` phase unchanged.
- R8: A cycle with `arm`=1 clears `synced` at the next edge. The next SYNC edge in one-shot mode then realigns again. Reset leaves the block armed.
- R9: While `rst_n` is low, `div_en`, `realign` and `synced` are all 0.
- R10: Two instances that have the same `div_code` and see the same SYNC edge on the same clock edge produce the same `div_en` in every cycle afterwards, even if they started from different phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External alignment level, asynchronous to the block |
| div_code | input | 3 | Divide ratio minus one (0 means divide by 1, 7 means divide by 8) |
| one_shot | input | 1 | 1 = realign only on the first event after arming; 0 = realign on every event |
| arm | input | 1 | Pulse high to clear the sticky flag and re-arm one-shot mode |
| div_en | output | 1 | Divided sample-rate clock enable, one input cycle wide |
| realign | output | 1 | One-cycle pulse in the first cycle of a realigned period |
| synced | output | 1 | Sticky flag, set by an accepted one-shot realignment |

## Verification
The hardest case to set up is a one-shot SYNC edge that arrives while the divider is out of phase with it. Only that case shows whether the edge really had no effect. The bench first aligns the divider, then raises SYNC so that the event lands one cycle after an enable. An accepted realignment at that point would move every following enable, so a wrongly accepted edge shows up directly at `div_en`. The multi-device requirement is tested with a second instance whose reset is released later, which gives it a different starting phase. Its enable is then compared cycle by cycle against the first instance after a shared SYNC edge.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  parameter int DIV_W = 3;

  typedef logic [DIV_W-1:0] code_t;

  // Wrap happens on a forced load or at the terminal count.
  function automatic logic cnt_wraps(code_t cnt, code_t term, logic load);
    return load || (cnt >= term);
  endfunction

  function automatic code_t cnt_next(code_t cnt, code_t term, logic load);
    if (cnt_wraps(cnt, term, load)) return '0;
    return cnt + 1'b1;
  endfunction
endpackage

// File: rtl/sclk_sync_edge.sv
module sclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sclk_align_ctrl.sv
module sclk_align_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic one_shot_i,
  input  logic arm_i,
  output logic accept_o,
  output logic realign_o,
  output logic synced_o
);
  logic synced_q;
  logic realign_q;

  assign accept_o = evt_i && (!one_shot_i || !synced_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q  <= 1'b0;
      realign_q <= 1'b0;
    end else begin
      realign_q <= accept_o;
      if (arm_i)                        synced_q <= 1'b0;
      else if (accept_o && one_shot_i)  synced_q <= 1'b1;
    end
  end

  assign realign_o = realign_q;
  assign synced_o  = synced_q;
endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt
  import sclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  code_t ratio_i,
  output logic  en_o
);
  code_t cnt_q;
  code_t term_q;
  code_t cnt_d;
  logic  wrap;
  logic  en_q;

  assign wrap  = cnt_wraps(cnt_q, term_q, load_i);
  assign cnt_d = cnt_next(cnt_q, term_q, load_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
      en_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= (cnt_d == '0);
      if (wrap) term_q <= ratio_i;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/sclk_div_align.sv
module sclk_div_align
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [DIV_W-1:0] div_code,
  input  logic             one_shot,
  input  logic             arm,
  output logic             div_en,
  output logic             realign,
  output logic             synced
);
  logic sync_evt;
  logic accept;

  sclk_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sync_in),
    .rise_o  (sync_evt)
  );

  sclk_align_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (sync_evt),
    .one_shot_i (one_shot),
    .arm_i      (arm),
    .accept_o   (accept),
    .realign_o  (realign),
    .synced_o   (synced)
  );

  sclk_phase_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .ratio_i (div_code),
    .en_o    (div_en)
  );
endmodule

module sclk_div_align_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_evt,
  input logic accept,
  input logic one_shot,
  input logic arm,
  input logic div_en,
  input logic realign,
  input logic synced
);
  // R1
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_evt);

  // R2
  realign_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (realign && div_en));

  // R6
  cont_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_shot && sync_evt) |=> realign);

  // R7
  synced_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_shot && synced && !arm) |=> synced);

  // R7
  synced_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> realign);

  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !synced);

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!div_en && !realign && !synced);
    end
  end
endmodule

bind sclk_div_align sclk_div_align_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_evt (sync_evt),
  .accept   (accept),
  .one_shot (one_shot),
  .arm      (arm),
  .div_en   (div_en),
  .realign  (realign),
  .synced   (synced)
);

// File: tb/sclk_div_align_tb.sv
module sclk_div_align_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_p = 1'b0;
  logic       sync_in = 1'b0;
  logic [2:0] div_code = 3'd3;
  logic       one_shot = 1'b0;
  logic       arm = 1'b0;
  logic       div_en, realign, synced;
  logic       div_en_p, realign_p, synced_p;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sclk_div_align u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .div_code(div_code),
    .one_shot(one_shot), .arm(arm),
    .div_en(div_en), .realign(realign), .synced(synced)
  );

  sclk_div_align u_peer (
    .clk(clk), .rst_n(rst_p), .sync_in(sync_in), .div_code(3'd7),
    .one_shot(1'b0), .arm(1'b0),
    .div_en(div_en_p), .realign(realign_p), .synced(synced_p)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Raise sync from a low level; returns at the negedge of the aligned cycle.
  task automatic fire_sync();
    sync_in = 1'b0;
    repeat (3) step();
    sync_in = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk(div_en, 1'b0, "R9 div_en in reset");
    chk(realign, 1'b0, "R9 realign in reset");
    chk(synced, 1'b0, "R9 synced in reset");
    rst_n = 1'b1;
    repeat (3) step();
    rst_p = 1'b1;
    step();
  endtask

  // R1 R2 R3 R6: continuous mode, long pulse, second edge off-phase
  task automatic t_continuous();
    one_shot = 1'b0;
    div_code = 3'd3;
    fire_sync();
    chk(realign, 1'b1, "R1 realign two edges after sample");
    chk(div_en, 1'b1, "R2 div_en on aligned cycle");
    for (int off = 1; off <= 6; off++) begin
      step();
      if (off == 4) sync_in = 1'b0;
      chk(div_en, (off % 4) == 0, "R3 divide by four pattern");
      chk(realign, 1'b0, "R1 long pulse is one event");
    end
    sync_in = 1'b1;
    for (int off = 7; off <= 13; off++) begin
      step();
      if (off == 9) begin
        chk(realign, 1'b1, "R6 off-phase edge realigns");
        chk(div_en, 1'b1, "R6 enable at new phase");
      end else if (off == 8) begin
        chk(div_en, 1'b1, "R6 old phase enable before load");
      end else begin
        chk(div_en, (off == 13), "R6 new phase pattern");
        chk(realign, 1'b0, "R2 realign single cycle");
      end
    end
    sync_in = 1'b0;
  endtask

  // R4
  task automatic t_ratio_one();
    one_shot = 1'b0;
    div_code = 3'd0;
    fire_sync();
    for (int off = 0; off < 8; off++) begin
      chk(div_en, 1'b1, "R4 divide by one every cycle");
      step();
    end
  endtask

  // R3
  task automatic t_ratio_eight();
    one_shot = 1'b0;
    div_code = 3'd7;
    fire_sync();
    chk(div_en, 1'b1, "R3 divide by eight aligned");
    for (int off = 1; off <= 17; off++) begin
      step();
      chk(div_en, (off % 8) == 0, "R3 divide by eight period");
    end
  endtask

  // R5
  task automatic t_ratio_change();
    one_shot = 1'b0;
    div_code = 3'd3;
    fire_sync();
    chk(div_en, 1'b1, "R5 aligned at divide by four");
    step();
    chk(div_en, 1'b0, "R5 offset one");
    div_code = 3'd1;
    for (int off = 2; off <= 8; off++) begin
      step();
      chk(div_en, (off == 4) || (off == 6) || (off == 8), "R5 change waits for wrap");
    end
  endtask

  // R7 R8
  task automatic t_one_shot();
    sync_in = 1'b0;
    one_shot = 1'b1;
    div_code = 3'd3;
    step();
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk(synced, 1'b0, "R8 arm clears synced");
    fire_sync();
    chk(realign, 1'b1, "R7 first edge realigns");
    chk(synced, 1'b1, "R7 synced set");
    chk(div_en, 1'b1, "R7 enable at aligned cycle");
    for (int off = 1; off <= 13; off++) begin
      step();
      if (off == 2) sync_in = 1'b0;
      if (off == 6) sync_in = 1'b1;
      chk(div_en, (off % 4) == 0, "R7 later edge leaves phase");
      chk(realign, 1'b0, "R7 later edge gives no pulse");
    end
    chk(synced, 1'b1, "R7 synced stays set");
    sync_in = 1'b0;
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk(synced, 1'b0, "R8 re-arm clears flag");
    fire_sync();
    chk(realign, 1'b1, "R8 edge after re-arm realigns");
    chk(synced, 1'b1, "R8 synced set again");
    sync_in = 1'b0;
  endtask

  // R10
  task automatic t_peer();
    one_shot = 1'b0;
    div_code = 3'd7;
    fire_sync();
    chk(realign_p, 1'b1, "R10 peer realigns on same edge");
    for (int off = 0; off < 16; off++) begin
      chk(div_en, div_en_p, "R10 peer enable matches");
      step();
    end
    sync_in = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_continuous();
    t_ratio_one();
    t_ratio_eight();
    t_ratio_change();
    t_one_shot();
    t_peer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule